// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out the atomic memory instructions of a 64-bit packet-filter instruction set. Each instruction is applied to a synchronous memory port as one indivisible read-modify-write. A core hands it one instruction with a single-cycle `start` pulse. The instruction arrives as the opcode byte, the 32-bit immediate that selects the operation, the base address from the destination register, a signed 16-bit offset, the source register value and the current value of register zero. The unit then reads the target location, computes the new value, writes it back when the operation calls for a write, and reports the result in a one-cycle `done` pulse. With that pulse come optional write-enables for the source register and register zero.

The control is a five-state machine:

- **IDLE** waits for `start`. A legal instruction moves to **READ**; an illegal one moves straight to **DONE**.
- **READ** holds a read request until `mem_ready`, captures the old value and moves to **CALC**.
- **CALC** forms the new value. It moves to **WRITE** when a store is needed, and to **DONE** when a compare-exchange finds a mismatch.
- **WRITE** holds a write request until `mem_ready` and then moves to **DONE**.
- **DONE** lasts one cycle and returns to **IDLE**.

`lock` is high in READ, CALC and WRITE, so other masters can be kept off the memory for the whole sequence.

Top module: `atomic_rmw_unit`

## Requirements
- R1: An opcode is accepted only with class bits [2:0]=3'b011, mode bits [7:5]=3'b110 and size bits [4:3] equal to 2'b00 (4-byte word, opcode 0xc3) or 2'b11 (8-byte doubleword, opcode 0xdb). Any other opcode gives `illegal` with `done` and no memory handshake.
- R2: The memory address is `base_addr` plus the sign-extended `offset`, and it is the same for the read and the write.
- R3: Immediates 0x00, 0x40, 0x50 and 0xa0 store old+src, old|src, old&src and old^src respectively. Without the fetch bit, neither register write-enable is raised.
- R4: When immediate bit 0 (fetch) is set on a legal operation, `src_we` pulses with `done` and `src_wdata` carries the memory value read before the update.
- R5: Immediate 0xe1 (exchange) stores the source value and returns the old memory value on `src_wdata`.
- R6: Immediate 0xf1 (compare-exchange) stores the source value when the old memory value equals register zero. In every case it pulses `r0_we` with `r0_wdata` equal to the old value.
- R7: A compare-exchange whose comparison fails makes exactly one memory handshake (the read) and leaves memory unchanged.
- R8: For word operations, only the low 32 bits of memory data, source and register zero take part. Written memory data and returned old values have their upper 32 bits cleared.
- R9: Immediates 0xe0, 0xf0, any value outside the listed set, and any immediate with bits [31:8] non-zero all give `illegal`. They cause no memory access and no register write-enable.
- R10: `mem_req` stays high with a stable address and direction until `mem_ready`, and `lock` is high whenever `mem_req` is.
- R11: `done` pulses for one cycle after the final handshake, or one cycle after `start` for an illegal instruction. The next cycle, `busy` and `lock` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction (sampled in IDLE) |
| opcode | input | 8 | Instruction opcode byte |
| imm | input | 32 | Immediate selecting the atomic operation |
| base_addr | input | ADDR_W | Destination register value used as base |
| offset | input | 16 | Signed address offset |
| src_val | input | DATA_W | Source register value |
| r0_val | input | DATA_W | Register zero value (compare operand) |
| busy | output | 1 | Unit is not idle |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | With done: instruction rejected |
| lock | output | 1 | Memory held for the read-modify-write |
| src_we | output | 1 | Write-enable for the source register |
| src_wdata | output | DATA_W | Value for the source register |
| r0_we | output | 1 | Write-enable for register zero |
| r0_wdata | output | DATA_W | Value for register zero |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_dword | output | 1 | Access is 8 bytes (else 4) |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready on a read |

## Verification
The assertions assume that `start` is raised only while `busy` is low. They also assume that the memory raises `mem_ready` only while a request is pending, so every handshake falls inside a READ or WRITE state. The bench keeps to this: its driver waits for each `done` before issuing the next instruction, and its memory model answers one cycle after seeing a request and drops `mem_ready` after each handshake.

// File: rtl/atom_pkg.sv
package atom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_CALC  = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } rmw_state_e;

    typedef enum logic [2:0] {
        AOP_ADD  = 3'd0,
        AOP_OR   = 3'd1,
        AOP_AND  = 3'd2,
        AOP_XOR  = 3'd3,
        AOP_SWAP = 3'd4,
        AOP_CAS  = 3'd5
    } atom_op_e;

    localparam logic [2:0] CLASS_STORE_REG = 3'b011;
    localparam logic [2:0] MODE_ATOMIC     = 3'b110;
    localparam logic [1:0] SIZE_WORD       = 2'b00;
    localparam logic [1:0] SIZE_DWORD      = 2'b11;

endpackage

// File: rtl/atom_decode.sv
module atom_decode
    import atom_pkg::*;
#(
    parameter int OPC_W = 8,
    parameter int IMM_W = 32
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [IMM_W-1:0] imm,
    output logic             legal,
    output logic             is_dword,
    output logic             fetch,
    output atom_op_e         op
);
    logic opc_ok;
    logic imm_ok;
    logic hi_zero;

    assign hi_zero  = (imm[IMM_W-1:8] == '0);
    assign is_dword = (opcode[4:3] == SIZE_DWORD);
    assign fetch    = imm[0];

    always_comb begin
        opc_ok = (opcode[2:0] == CLASS_STORE_REG) &&
                 (opcode[7:5] == MODE_ATOMIC) &&
                 ((opcode[4:3] == SIZE_WORD) || (opcode[4:3] == SIZE_DWORD));
        imm_ok = 1'b1;
        op     = AOP_ADD;
        unique case (imm[7:1])
            7'h00: op = AOP_ADD;
            7'h20: op = AOP_OR;
            7'h28: op = AOP_AND;
            7'h50: op = AOP_XOR;
            7'h70: begin op = AOP_SWAP; imm_ok = imm[0]; end
            7'h78: begin op = AOP_CAS;  imm_ok = imm[0]; end
            default: imm_ok = 1'b0;
        endcase
        legal = opc_ok && imm_ok && hi_zero;
    end
endmodule

// File: rtl/atom_addr.sv
module atom_addr #(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - OFF_W;
    logic [ADDR_W-1:0] off_ext;

    assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
    assign addr    = base + off_ext;
endmodule

// File: rtl/atom_alu.sv
module atom_alu
    import atom_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  atom_op_e          op,
    input  logic              is_dword,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] cmp,
    output logic [DATA_W-1:0] new_val,
    output logic              do_write
);
    localparam int HALF_W = DATA_W / 2;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] s_m;
    logic [DATA_W-1:0] c_m;
    logic [DATA_W-1:0] raw;

    assign mask = is_dword ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    assign s_m  = src & mask;
    assign c_m  = cmp & mask;

    always_comb begin
        raw      = s_m;
        do_write = 1'b1;
        unique case (op)
            AOP_ADD:  raw = old_val + s_m;
            AOP_OR:   raw = old_val | s_m;
            AOP_AND:  raw = old_val & s_m;
            AOP_XOR:  raw = old_val ^ s_m;
            AOP_SWAP: raw = s_m;
            AOP_CAS: begin
                raw      = s_m;
                do_write = (old_val == c_m);
            end
            default: raw = s_m;
        endcase
        new_val = raw & mask;
    end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import atom_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [31:0]       imm,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [15:0]       offset,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] r0_val,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              lock,
    output logic              src_we,
    output logic [DATA_W-1:0] src_wdata,
    output logic              r0_we,
    output logic [DATA_W-1:0] r0_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_dword,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int HALF_W = DATA_W / 2;

    rmw_state_e        state_q, state_d;
    atom_op_e          dec_op, op_q;
    logic              dec_legal, dec_dword, dec_fetch;
    logic [ADDR_W-1:0] eff_addr;
    logic              dword_q, fetch_q, illegal_q, wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] src_q, r0_q, old_q, new_q;
    logic [DATA_W-1:0] alu_new;
    logic              alu_wr;
    logic [DATA_W-1:0] rd_masked;

    atom_decode #(.OPC_W(8), .IMM_W(32)) u_dec (
        .opcode   (opcode),
        .imm      (imm),
        .legal    (dec_legal),
        .is_dword (dec_dword),
        .fetch    (dec_fetch),
        .op       (dec_op)
    );

    atom_addr #(.ADDR_W(ADDR_W), .OFF_W(16)) u_addr (
        .base   (base_addr),
        .offset (offset),
        .addr   (eff_addr)
    );

    atom_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (op_q),
        .is_dword (dword_q),
        .old_val  (old_q),
        .src      (src_q),
        .cmp      (r0_q),
        .new_val  (alu_new),
        .do_write (alu_wr)
    );

    assign rd_masked = dword_q ? mem_rdata : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = dec_legal ? ST_READ : ST_DONE;
            ST_READ:  if (mem_ready) state_d = ST_CALC;
            ST_CALC:  state_d = alu_wr ? ST_WRITE : ST_DONE;
            ST_WRITE: if (mem_ready) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= AOP_ADD;
            dword_q   <= 1'b0;
            fetch_q   <= 1'b0;
            illegal_q <= 1'b0;
            wr_q      <= 1'b0;
            addr_q    <= '0;
            src_q     <= '0;
            r0_q      <= '0;
            old_q     <= '0;
            new_q     <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    op_q      <= dec_op;
                    dword_q   <= dec_dword;
                    fetch_q   <= dec_fetch;
                    illegal_q <= !dec_legal;
                    addr_q    <= eff_addr;
                    src_q     <= src_val;
                    r0_q      <= r0_val;
                end
                ST_READ: if (mem_ready) old_q <= rd_masked;
                ST_CALC: begin
                    new_q <= alu_new;
                    wr_q  <= alu_wr;
                end
                ST_WRITE: ;
                ST_DONE:  ;
                default:  ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        lock      = (state_q == ST_READ) || (state_q == ST_CALC) || (state_q == ST_WRITE);
        mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE) && wr_q;
        mem_dword = dword_q;
        mem_addr  = addr_q;
        mem_wdata = new_q;
        done      = (state_q == ST_DONE);
        illegal   = done && illegal_q;
        src_we    = done && !illegal_q && fetch_q;
        r0_we     = done && !illegal_q && (op_q == AOP_CAS);
        src_wdata = old_q;
        r0_wdata  = old_q;
    end
endmodule

// File: rtl/atom_rmw_chk.sv
module atom_rmw_chk #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              illegal,
    input logic              lock,
    input logic              src_we,
    input logic              r0_we,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_dword,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready
);
    localparam int HALF_W = DATA_W / 2;

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_lock_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> lock);

    p_done_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !lock && !busy && !done);

    p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !src_we && !r0_we && !mem_req);

    p_r0_only_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r0_we || src_we) |-> done);

    p_word_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && !mem_dword |-> mem_wdata[DATA_W-1:HALF_W] == '0);
endmodule

bind atomic_rmw_unit atom_rmw_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .lock      (lock),
    .src_we    (src_we),
    .r0_we     (r0_we),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_dword (mem_dword),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/sim_atomic_rmw_unit.sv
module sim_atomic_rmw_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [31:0] imm = '0;
    logic [63:0] base_addr = '0;
    logic [15:0] offset = '0;
    logic [63:0] src_val = '0;
    logic [63:0] r0_val = '0;
    logic        busy, done, illegal, lock, src_we, r0_we;
    logic [63:0] src_wdata, r0_wdata;
    logic        mem_req, mem_we, mem_dword;
    logic [63:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [63:0] mem_rdata;

    logic [63:0] bmem [8];
    int          hs = 0;
    logic [63:0] last_addr = '0;
    int          checks = 0;
    int          fails = 0;

    typedef struct {
        bit          ill;
        bit          swe;
        logic [63:0] sd;
        bit          rwe;
        logic [63:0] rd;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    atomic_rmw_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .imm(imm),
        .base_addr(base_addr), .offset(offset), .src_val(src_val), .r0_val(r0_val),
        .busy(busy), .done(done), .illegal(illegal), .lock(lock),
        .src_we(src_we), .src_wdata(src_wdata), .r0_we(r0_we), .r0_wdata(r0_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_dword(mem_dword), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = bmem[mem_addr[5:3]];

    // memory model: answers one cycle after a request, drops ready after each handshake
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
        end else begin
            mem_ready <= mem_req && !mem_ready;
            if (mem_req && mem_ready) begin
                hs        <= hs + 1;
                last_addr <= mem_addr;
                if (mem_we) bmem[mem_addr[5:3]] <= mem_wdata;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected results as completions appear
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R11 unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(illegal == e.ill, {e.tag, " illegal"}, {63'd0, illegal}, {63'd0, e.ill});
                chk(src_we == e.swe, {e.tag, " src_we"}, {63'd0, src_we}, {63'd0, e.swe});
                chk(r0_we == e.rwe, {e.tag, " r0_we"}, {63'd0, r0_we}, {63'd0, e.rwe});
                if (e.swe) chk(src_wdata == e.sd, {e.tag, " src_wdata"}, src_wdata, e.sd);
                if (e.rwe) chk(r0_wdata == e.rd, {e.tag, " r0_wdata"}, r0_wdata, e.rd);
            end
        end
    end

    // driver: computes expected results, pushes them, runs one instruction
    task automatic run(input logic [7:0] opc, input logic [31:0] im, input logic [63:0] base,
                       input logic [15:0] off, input logic [63:0] src, input logic [63:0] r0,
                       input string tag);
        logic [63:0] addr, mask, o, s, r, n, old, exp_mem;
        bit legal, dw, wr;
        int exp_hs, hs0, idx;
        exp_t e;
        addr  = base + {{48{off[15]}}, off};
        idx   = int'(addr[5:3]);
        dw    = (opc == 8'hdb);
        legal = ((opc == 8'hc3) || dw) && (im[31:8] == 24'd0) &&
                (im[7:0] inside {8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51,
                                 8'ha0, 8'ha1, 8'he1, 8'hf1});
        mask  = dw ? 64'hffff_ffff_ffff_ffff : 64'h0000_0000_ffff_ffff;
        old   = bmem[idx];
        o = old & mask; s = src & mask; r = r0 & mask;
        wr = 1'b1;
        case (im[7:4])
            4'h0: n = o + s;
            4'h4: n = o | s;
            4'h5: n = o & s;
            4'ha: n = o ^ s;
            4'hf: begin n = s; wr = (o == r); end
            default: n = s;
        endcase
        n &= mask;
        exp_mem = (legal && wr) ? n : old;
        exp_hs  = legal ? (wr ? 2 : 1) : 0;
        e.ill = !legal; e.swe = legal && im[0]; e.sd = o;
        e.rwe = legal && (im[7:4] == 4'hf); e.rd = o; e.tag = tag;
        sb.push_back(e);
        hs0 = hs;
        @(negedge clk);
        opcode = opc; imm = im; base_addr = base; offset = off; src_val = src; r0_val = r0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(bmem[idx] == exp_mem, {tag, " memory"}, bmem[idx], exp_mem);
        chk((hs - hs0) == exp_hs, {tag, " handshakes"}, 64'(hs - hs0), 64'(exp_hs));
        if (legal) chk(last_addr == addr, {tag, " address R2"}, last_addr, addr);
        chk(!busy && !lock, {tag, " idle after done R11"}, {62'd0, busy, lock}, 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) bmem[i] = 64'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !lock && !done && !mem_req, "reset state",
            {60'd0, busy, lock, done, mem_req}, 64'd0);

        bmem[1] = 64'h0000_0001_ffff_fff0;
        run(8'hdb, 32'h00, 64'h1000, 16'h0008, 64'h0000_0000_0000_0020, 64'h0, "R3 dword add");
        bmem[2] = 64'hf0f0_0000_1111_0000;
        run(8'hdb, 32'h41, 64'h1020, 16'hfff0, 64'h0f0f_0000_0000_2222, 64'h0, "R4 R2 or fetch negoff");
        bmem[3] = 64'hffff_0000_ffff_0000;
        run(8'hdb, 32'h51, 64'h1018, 16'h0000, 64'h0ff0_0ff0_0ff0_0ff0, 64'h0, "R4 and fetch");
        bmem[4] = 64'h1234_5678_9abc_def0;
        run(8'hdb, 32'ha0, 64'h1020, 16'h0000, 64'hffff_ffff_0000_0000, 64'h0, "R3 xor");
        bmem[5] = 64'hdead_beef_cafe_f00d;
        run(8'hdb, 32'he1, 64'h1028, 16'h0000, 64'h0102_0304_0506_0708, 64'h0, "R5 exchange");
        bmem[6] = 64'h5555_aaaa_5555_aaaa;
        run(8'hdb, 32'hf1, 64'h1030, 16'h0000, 64'h7777, 64'h5555_aaaa_5555_aaaa, "R6 cas equal");
        run(8'hdb, 32'hf1, 64'h1030, 16'h0000, 64'h8888, 64'h1, "R7 cas mismatch");
        bmem[7] = 64'haaaa_bbbb_ffff_ffff;
        run(8'hc3, 32'h01, 64'h1038, 16'h0000, 64'h1234_5678_0000_0001, 64'h0, "R8 word add wrap");
        bmem[0] = 64'h9999_9999_0000_0042;
        run(8'hc3, 32'hf1, 64'h1000, 16'h0000, 64'hffff_ffff_0000_0077, 64'h1234_0000_0000_0042, "R8 R6 word cas");
        run(8'hc3, 32'he1, 64'h1000, 16'h0000, 64'hffff_ffff_1111_2222, 64'h0, "R8 R5 word exchange");
        run(8'hdb, 32'he0, 64'h1000, 16'h0000, 64'h1, 64'h0, "R9 exchange no fetch");
        run(8'hdb, 32'hf0, 64'h1000, 16'h0000, 64'h1, 64'h0, "R9 cas no fetch");
        run(8'hdb, 32'h10, 64'h1000, 16'h0000, 64'h1, 64'h0, "R9 unlisted imm");
        run(8'hdb, 32'h100, 64'h1000, 16'h0000, 64'h1, 64'h0, "R9 upper imm bits");
        run(8'hd3, 32'h00, 64'h1000, 16'h0000, 64'h1, 64'h0, "R1 byte size");
        run(8'hcb, 32'h00, 64'h1000, 16'h0000, 64'h1, 64'h0, "R1 half size");
        run(8'h7b, 32'h00, 64'h1000, 16'h0000, 64'h1, 64'h0, "R1 plain store mode");
        chk(sb.size() == 0, "R11 all completions seen", 64'(sb.size()), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule